// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block folds a large number of level-sensitive interrupt sources into one combined request line per group of eight sources. Each source passes through a synchronizer. It is gated by its own enable bit and then ORed with the other enabled sources of its group, giving a registered group output. A source's global number is `group*8 + bit`. Software services a group by reading the pending byte and handling the lowest set bit first.

Software reaches the block over a simple memory-mapped register port: select, write strobe, address, write data and read data. Four consecutive groups share one 32-bit window, and each group owns one byte lane of it. Windows repeat every 0x10 bytes. Enables change only through a write-one-to-set register and a write-one-to-clear register. A third register reports the pending sources.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0, every group output is 0 and the read data is 0.
- R2: A write to window offset 0x0 sets the enable of each source whose write-data bit is 1. Bits written as 0 leave their enables unchanged.
- R3: A write to window offset 0x4 clears the enable of each source whose write-data bit is 1. Bits written as 0 leave their enables unchanged.
- R4: A read of offset 0x0 or 0x4 returns the current enable bits of the window.
- R5: A read of offset 0xC returns, for every source in the window, its synchronized level ANDed with its enable.
- R6: Group output n is the OR of the enabled, synchronized sources of group n. It changes exactly three clock edges after a source input changes (two synchronizer stages and one output register), and two edges after the enabling write.
- R7: Group n sits in the window at address (n/4)*0x10, in bits [8*(n%4)+7 : 8*(n%4)]. Source bit b of group n is input `src_i[n*8+b]`.
- R8: Writes to offset 0x8, to offset 0xC, to any offset not a multiple of 4 and to windows past the last group change no enable. Reads of offset 0x8, unaligned offsets and windows past the last group return 0.
- R9: Read data is loaded on the clock edge that ends a read access and holds its value at every other edge.
- R10: A group output falls once its sources drop or are disabled, because outputs follow levels and store no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_GROUPS*8 | Level interrupt sources, group-major |
| sel_i | input | 1 | Register access in this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | NUM_GROUPS | Combined request per group |

## Verification
A source change is visible on the group outputs and in the pending register three edges after it is driven. An enable write reaches the outputs two edges later, and read data shows up at the edge that ends the read. The bench drives every input on the falling edge. It waits four full cycles after any source or enable change before it compares outputs or issues a status read. It samples read data on the falling edge that follows the read. One directed case samples the output after the second edge and after the third edge, to pin down the exact latency.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned LANE_W        = 8;
   localparam int unsigned LANES_PER_WIN = 4;
   localparam int unsigned WIN_W         = LANE_W * LANES_PER_WIN;
   localparam int unsigned OFF_W         = 4;

   localparam logic [OFF_W-1:0] OFF_EN_SET  = 4'h0;
   localparam logic [OFF_W-1:0] OFF_EN_CLR  = 4'h4;
   localparam logic [OFF_W-1:0] OFF_PENDING = 4'hC;

   typedef enum logic [1:0] {
      ACC_NONE,
      ACC_EN_SET,
      ACC_EN_CLR,
      ACC_PENDING
   } acc_kind_e;

   function automatic acc_kind_e decode_offset(input logic [OFF_W-1:0] off);
      case (off)
         OFF_EN_SET:  return ACC_EN_SET;
         OFF_EN_CLR:  return ACC_EN_CLR;
         OFF_PENDING: return ACC_PENDING;
         default:     return ACC_NONE;
      endcase
   endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irqc_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_window.sv
module irqc_window
   import irqc_pkg::*;
#(
   parameter int unsigned LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES*LANE_W-1:0] src_sync_i,
   input  logic             set_we_i,
   input  logic             clr_we_i,
   input  logic [WIN_W-1:0] wdata_i,
   output logic [WIN_W-1:0] en_o,
   output logic [WIN_W-1:0] pend_o,
   output logic [LANES-1:0] irq_o
);
   localparam int unsigned BITS = LANES * LANE_W;

   if (LANES < 1 || LANES > LANES_PER_WIN) begin : g_bad_lanes
      $error("irqc_window: LANES out of range");
   end

   logic [BITS-1:0]  en_q;
   logic [BITS-1:0]  wmask;
   logic [BITS-1:0]  pend;
   logic [LANES-1:0] irq_q;

   if (BITS == WIN_W) begin : g_full
      assign wmask = wdata_i;
   end else begin : g_part
      assign wmask = wdata_i[BITS-1:0];
   end

   // write-one-to-set / write-one-to-clear enable storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        en_q <= '0;
      else if (set_we_i) en_q <= en_q | wmask;
      else if (clr_we_i) en_q <= en_q & ~wmask;
   end

   assign pend = src_sync_i & en_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q[l] <= 1'b0;
         else        irq_q[l] <= |pend[l*LANE_W +: LANE_W];
      end

      // R10: an output is only raised by a lane that had an enable one edge earlier
      p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
         irq_q[l] |-> $past(en_q[l*LANE_W +: LANE_W] != '0));
   end

   always_comb begin
      en_o   = '0;
      pend_o = '0;
      en_o[BITS-1:0]   = en_q;
      pend_o[BITS-1:0] = pend;
   end

   assign irq_o = irq_q;

   p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_we_i |=> ((en_q & $past(wmask)) == $past(wmask)));
   p_set_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_we_i |=> ((en_q & $past(en_q)) == $past(en_q)));
   p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we_i |=> ((en_q & $past(wmask)) == '0));
   p_clr_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we_i |=> ((en_q | $past(wmask)) == ($past(en_q) | $past(wmask))));
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we_i && !clr_we_i) |=> $stable(en_q));
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_GROUPS  = 20,
   parameter int unsigned GROUP_W     = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_GROUPS*GROUP_W-1:0] src_i,
   input  logic                          sel_i,
   input  logic                          wr_i,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic [31:0]                   wdata_i,
   output logic [31:0]                   rdata_o,
   output logic [NUM_GROUPS-1:0]         irq_o
);
   localparam int unsigned NUM_SRC   = NUM_GROUPS * GROUP_W;
   localparam int unsigned NUM_WIN   = (NUM_GROUPS + LANES_PER_WIN - 1) / LANES_PER_WIN;
   localparam int unsigned WIN_IDX_W = ADDR_W - OFF_W;

   if (GROUP_W != LANE_W) begin : g_bad_group_w
      $error("irq_group_combiner: GROUP_W must equal one byte lane");
   end
   if (NUM_GROUPS < 1) begin : g_bad_groups
      $error("irq_group_combiner: NUM_GROUPS must be positive");
   end
   if (ADDR_W <= OFF_W || NUM_WIN > (1 << WIN_IDX_W)) begin : g_bad_addr
      $error("irq_group_combiner: ADDR_W too small for the window count");
   end

   logic [NUM_SRC-1:0]   src_sync;
   logic [WIN_IDX_W-1:0] win_idx;
   logic [OFF_W-1:0]     win_off;
   acc_kind_e            acc;
   logic [WIN_W-1:0]     en_w   [NUM_WIN];
   logic [WIN_W-1:0]     pend_w [NUM_WIN];
   logic [NUM_WIN-1:0]   set_we;
   logic [NUM_WIN-1:0]   clr_we;
   logic [31:0]          rd_d;
   logic [31:0]          rdata_q;

   irqc_sync #(
      .WIDTH  (NUM_SRC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_i),
      .q_o   (src_sync)
   );

   assign win_idx = addr_i[ADDR_W-1:OFF_W];
   assign win_off = addr_i[OFF_W-1:0];

   always_comb begin
      if (int'(win_idx) < int'(NUM_WIN)) acc = decode_offset(win_off);
      else                               acc = ACC_NONE;
   end

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam int unsigned LEFT  = NUM_GROUPS - w * LANES_PER_WIN;
      localparam int unsigned LANES = (LEFT >= LANES_PER_WIN) ? LANES_PER_WIN : LEFT;
      localparam int unsigned BASE  = w * WIN_W;

      assign set_we[w] = sel_i && wr_i && (win_idx == WIN_IDX_W'(w)) && (acc == ACC_EN_SET);
      assign clr_we[w] = sel_i && wr_i && (win_idx == WIN_IDX_W'(w)) && (acc == ACC_EN_CLR);

      irqc_window #(
         .LANES (LANES)
      ) u_window (
         .clk        (clk),
         .rst_n      (rst_n),
         .src_sync_i (src_sync[BASE +: LANES*LANE_W]),
         .set_we_i   (set_we[w]),
         .clr_we_i   (clr_we[w]),
         .wdata_i    (wdata_i),
         .en_o       (en_w[w]),
         .pend_o     (pend_w[w]),
         .irq_o      (irq_o[w*LANES_PER_WIN +: LANES])
      );
   end

   always_comb begin
      rd_d = '0;
      for (int w = 0; w < int'(NUM_WIN); w++) begin
         if (win_idx == WIN_IDX_W'(w)) begin
            case (acc)
               ACC_EN_SET, ACC_EN_CLR: rd_d = en_w[w];
               ACC_PENDING:            rd_d = pend_w[w];
               default:                rd_d = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             rdata_q <= '0;
      else if (sel_i && !wr_i) rdata_q <= rd_d;
   end

   assign rdata_o = rdata_q;

   p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_i && !wr_i) |=> $stable(rdata_o));
   p_unmapped_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && !wr_i && acc == ACC_NONE) |=> (rdata_o == '0));
   p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({set_we, clr_we}));
endmodule

// File: tb/irq_group_combiner_bench.sv
module irq_group_combiner_bench;
   localparam int NG   = 20;
   localparam int NSRC = NG * 8;
   localparam int NWIN = (NG + 3) / 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src = '0;
   logic            sel = 1'b0;
   logic            wr = 1'b0;
   logic [7:0]      addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic [NG-1:0]   irq;

   logic [NSRC-1:0] m_en = '0;
   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   irq_group_combiner u_irq_group_combiner (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (src),
      .sel_i   (sel),
      .wr_i    (wr),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .irq_o   (irq)
   );

   function automatic logic [31:0] exp_en(input int w);
      logic [31:0] r = '0;
      for (int b = 0; b < 32; b++)
         if (w*32 + b < NSRC) r[b] = m_en[w*32 + b];
      return r;
   endfunction

   function automatic logic [31:0] exp_pend(input int w);
      logic [31:0] r = '0;
      for (int b = 0; b < 32; b++)
         if (w*32 + b < NSRC) r[b] = m_en[w*32 + b] & src[w*32 + b];
      return r;
   endfunction

   function automatic logic [NG-1:0] exp_irq();
      logic [NG-1:0] r;
      for (int g = 0; g < NG; g++) r[g] = |(m_en[g*8 +: 8] & src[g*8 +: 8]);
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
      if (a[7:4] < NWIN && a[3:0] == 4'h0) begin
         for (int b = 0; b < 32; b++)
            if (d[b] && int'(a[7:4])*32 + b < NSRC) m_en[int'(a[7:4])*32 + b] = 1'b1;
      end else if (a[7:4] < NWIN && a[3:0] == 4'h4) begin
         for (int b = 0; b < 32; b++)
            if (d[b] && int'(a[7:4])*32 + b < NSRC) m_en[int'(a[7:4])*32 + b] = 1'b0;
      end
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      @(negedge clk);
      sel = 1'b0;
      d = rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rdata", 64'(rdata), 64'h0);
      check("R1 irq", 64'(irq), 64'h0);
      rst_n = 1'b1;
      src = '1;
      settle();
      check("R1 irq disabled after reset", 64'(irq), 64'h0);
      for (int w = 0; w < NWIN; w++) begin
         bus_read(8'(w*16), rd);
         check("R1 enables zero", 64'(rd), 64'h0);
      end
      src = '0;

      // R7/R2/R4: group 5 bit 3 -> window 1, lane 1
      bus_write(8'h10, 32'h1 << 11);
      bus_read(8'h10, rd);
      check("R2 R7 set readback", 64'(rd), 64'h0000_0800);
      bus_read(8'h14, rd);
      check("R4 read via clear offset", 64'(rd), 64'h0000_0800);
      bus_write(8'h10, 32'h0000_0001);
      bus_read(8'h10, rd);
      check("R2 zero bits keep", 64'(rd), 64'h0000_0801);
      bus_write(8'h14, 32'h0000_0001);
      bus_read(8'h10, rd);
      check("R3 clear selected", 64'(rd), 64'h0000_0800);

      // R6 latency: source 5*8+3 = 43
      src[43] = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R6 not yet after two edges", 64'(irq[5]), 64'h0);
      @(negedge clk);
      check("R6 group 5 after three edges", 64'(irq), 64'(20'h00020));
      bus_read(8'h1C, rd);
      check("R5 pending", 64'(rd), 64'h0000_0800);

      // R10: level drop and disable drop
      src[43] = 1'b0;
      settle();
      check("R10 drop on source low", 64'(irq), 64'h0);
      src[43] = 1'b1;
      settle();
      bus_write(8'h14, 32'h0000_0800);
      settle();
      check("R10 drop on disable", 64'(irq), 64'h0);
      src[43] = 1'b0;

      // R8: ignored writes and zero reads
      bus_write(8'h10, 32'h00FF_0000);
      bus_write(8'h18, 32'hFFFF_FFFF);
      bus_write(8'h1C, 32'hFFFF_FFFF);
      bus_write(8'h11, 32'hFFFF_FFFF);
      bus_write(8'h15, 32'hFFFF_FFFF);
      bus_write(8'h50, 32'hFFFF_FFFF);
      bus_write(8'h54, 32'hFFFF_FFFF);
      bus_read(8'h10, rd);
      check("R8 ignored writes", 64'(rd), 64'h00FF_0000);
      bus_read(8'h18, rd);
      check("R8 read offset 8", 64'(rd), 64'h0);
      bus_read(8'h12, rd);
      check("R8 read unaligned", 64'(rd), 64'h0);
      bus_read(8'h50, rd);
      check("R8 read past last window", 64'(rd), 64'h0);

      // R9: read data holds across idle cycles
      bus_read(8'h10, rd);
      repeat (3) @(negedge clk);
      check("R9 rdata hold", 64'(rdata), 64'h00FF_0000);

      // random mix, R2 R3 R5 R6 R7
      for (int it = 0; it < 300; it++) begin
         int op = int'($urandom_range(0, 2));
         int w  = int'($urandom_range(0, NWIN - 1));
         if (op == 0) bus_write(8'(w*16), $urandom());
         else if (op == 1) bus_write(8'(w*16 + 4), $urandom());
         else begin
            for (int k = 0; k < NSRC; k += 32) src[k +: 32] = $urandom();
         end
         settle();
         check("R6 random irq", 64'(irq), 64'(exp_irq()));
         w = int'($urandom_range(0, NWIN - 1));
         bus_read(8'(w*16 + 12), rd);
         check("R5 random pending", 64'(rd), 64'(exp_pend(w)));
         bus_read(8'(w*16), rd);
         check("R2 R3 random enables", 64'(rd), 64'(exp_en(w)));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule